// File: doc/BRIEF.md
# One-Time-Programmable Row Command Engine

This block sits between a 32-bit register bus and an array of one-time-programmable fuse rows. Each row is 256 bits wide. The lower 128 bits hold four data words and the upper 128 bits hold four admin words, and bit 0 of admin word 0 marks the row as valid. Software runs a command in four steps:

1. Write a byte address to the address register.
2. Optionally load the program payload and program admin registers.
3. Write the control register with the start bit set and a command code in bits 7:4.
4. Poll the ready flag or the done flag, then read back the status and the result registers.

A read copies a whole row into the read result registers. A program merges the payload into the stored row by OR, so a fuse bit can only move from 0 to 1. A successful program also sets the row's valid flag.

Programming is blocked by two sources, either of which is enough:

- an external write-protect pin, visible in bit 30 of a protection register;
- a soft protect bit in bit 3 of the same register, which resets to protected.

The protection register lives in a second window, selected by bus address bit 12. The command window uses these offsets:

| Offset | Register |
|---|---|
| 0x00 | general status |
| 0x04 | read status |
| 0x08 | program status |
| 0x10 | address |
| 0x14 | control |
| 0x20 | read data words |
| 0x30 | read admin words |
| 0x40 | program data words |
| 0x50 | program admin words |

Top module: `fuse_cmd_engine`

## Requirements
- R1: After reset, general status bit 0 (ready) is 1, control bit 16 (done) is 0, read status and program status are 0, and protection register bit 3 (soft protect) is 1.
- R2: Reading a row that was never programmed returns four zero data words, four zero admin words and read status 0.
- R3: A start with code 0xF (read) holds ready low for exactly READ_LAT cycles, and a start with code 0xA (program) holds it low for exactly PROG_LAT cycles. A start written while ready is low is ignored.
- R4: Done (control bit 16) clears on an accepted start and sets in the same cycle that ready returns high.
- R5: A program ORs the program data words into the row's data and the program admin words into its admin words, and it sets admin word 0 bit 0. Bits already set stay set.
- R6: A read places row data word i at offset 0x20+4i and admin word i at offset 0x30+4i. Data word 0 is row bits 31:0 and admin word 0 is row bits 159:128.
- R7: When protection bit 30 (the external pin) or bit 3 (soft protect) is set at start, a program sets program status bit 0 and leaves the row unchanged. A program that is allowed clears program status.
- R8: An address with nonzero bits 3:0, or an address of ROWS*16 or more, makes a read set read status bit 0 and return all-zero data and admin words. It makes a program set program status bit 0 and leave the array unchanged.
- R9: Writes to the address and payload registers while ready is low are dropped.
- R10: Control bits 7:4 read back the last accepted command code, and control bit 0 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 13 | Byte address; bit 12 selects the protection window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; data appears on bus_rdata one cycle later |
| bus_rdata | output | 32 | Registered read data |
| ext_wp | input | 1 | External write-protect pin |

## Verification
The assertions assume that ext_wp and the bus strobes are synchronous to clk. They also assume that a command's outcome depends only on the protection state sampled in the start cycle. The bench changes ext_wp and the soft protect bit only while the engine is idle, and it issues one bus access per cycle. It polls status with a held read strobe, so every sample reflects the registered state of the cycle before. The latency counts are derived from that one-cycle offset.

// File: rtl/fuse_pkg.sv
package fuse_pkg;
  localparam int unsigned ROW_BITS  = 256;
  localparam int unsigned HALF_BITS = 128;

  localparam logic [7:0] OFF_GSTAT = 8'h00;
  localparam logic [7:0] OFF_RSTAT = 8'h04;
  localparam logic [7:0] OFF_PSTAT = 8'h08;
  localparam logic [7:0] OFF_ADDR  = 8'h10;
  localparam logic [7:0] OFF_CTRL  = 8'h14;
  localparam logic [3:0] GRP_RDAT  = 4'h2;
  localparam logic [3:0] GRP_RADM  = 4'h3;
  localparam logic [3:0] GRP_PDAT  = 4'h4;
  localparam logic [3:0] GRP_PADM  = 4'h5;

  localparam logic [3:0] CODE_READ = 4'hF;
  localparam logic [3:0] CODE_PROG = 4'hA;

  typedef enum logic [1:0] {OP_NONE, OP_READ, OP_PROG} op_e;
endpackage

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int unsigned ROWS  = 16,
  parameter int unsigned WIDTH = 256,
  localparam int unsigned IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WIDTH-1:0] rd_q,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [WIDTH-1:0] wr_d
);
  logic [WIDTH-1:0] mem [ROWS];

  // fuses start blank; contents survive reset
  initial begin
    for (int i = 0; i < ROWS; i++) mem[i] = '0;
  end

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_d;
    rd_q <= mem[rd_idx];
  end
endmodule

// File: rtl/cmd_seq.sv
module cmd_seq
  import fuse_pkg::*;
#(
  parameter int unsigned ROWS     = 16,
  parameter int unsigned READ_LAT = 8,
  parameter int unsigned PROG_LAT = 32,
  localparam int unsigned IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int unsigned CNT_W = $clog2(PROG_LAT + 1) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [3:0]       cmd_in,
  input  logic [31:0]      addr_in,
  input  logic             wp_in,
  output logic             busy,
  output logic             done,
  output logic             finish,
  output op_e              op,
  output logic             fault,
  output logic [IDX_W-1:0] row_idx,
  output logic [3:0]       cmd_q
);
  localparam logic [31:0] LIMIT = 32'(ROWS * 16);
  localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(READ_LAT - 1);
  localparam logic [CNT_W-1:0] PG_LOAD = CNT_W'(PROG_LAT - 1);

  logic [CNT_W-1:0] cnt;
  op_e              op_next;
  logic             addr_ok;

  always_comb begin
    unique case (cmd_in)
      CODE_READ: op_next = OP_READ;
      CODE_PROG: op_next = OP_PROG;
      default:   op_next = OP_NONE;
    endcase
    addr_ok = (addr_in[3:0] == 4'h0) && (addr_in < LIMIT);
  end

  assign finish = busy && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      op      <= OP_NONE;
      fault   <= 1'b0;
      row_idx <= '0;
      cmd_q   <= 4'h0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      done    <= 1'b0;
      op      <= op_next;
      cmd_q   <= cmd_in;
      fault   <= !addr_ok || ((op_next == OP_PROG) && wp_in);
      row_idx <= addr_in[IDX_W+3:4];
      cnt     <= (op_next == OP_PROG) ? PG_LOAD : RD_LOAD;
    end else if (finish) begin
      busy <= 1'b0;
      done <= 1'b1;
    end else if (busy) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fuse_cmd_engine.sv
module fuse_cmd_engine
  import fuse_pkg::*;
#(
  parameter int unsigned ROWS     = 16,
  parameter int unsigned READ_LAT = 8,
  parameter int unsigned PROG_LAT = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [12:0] bus_addr,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  input  logic        bus_rd,
  output logic [31:0] bus_rdata,
  input  logic        ext_wp
);
  localparam int unsigned IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1;

  logic [7:0]        off;
  logic              win_prot;
  logic              cfg_wr;
  logic              start_fire;
  logic              soft_wp;
  logic [31:0]       addr_q;
  logic [3:0][31:0]  pdat, padm, rdat, radm;
  logic [31:0]       rd_stat, pg_stat;

  logic              seq_busy, seq_done, seq_finish, seq_fault;
  op_e               seq_op;
  logic [IDX_W-1:0]  seq_row;
  logic [3:0]        seq_cmd;

  logic [ROW_BITS-1:0] arr_q, arr_wd;
  logic                arr_we;

  assign off        = bus_addr[7:0];
  assign win_prot   = bus_addr[12];
  assign cfg_wr     = bus_wr && !win_prot && !seq_busy;
  assign start_fire = cfg_wr && (off == OFF_CTRL) && bus_wdata[0];

  cmd_seq #(
    .ROWS(ROWS), .READ_LAT(READ_LAT), .PROG_LAT(PROG_LAT)
  ) u_seq (
    .clk(clk), .rst(rst),
    .start(start_fire), .cmd_in(bus_wdata[7:4]), .addr_in(addr_q),
    .wp_in(ext_wp || soft_wp),
    .busy(seq_busy), .done(seq_done), .finish(seq_finish),
    .op(seq_op), .fault(seq_fault), .row_idx(seq_row), .cmd_q(seq_cmd)
  );

  assign arr_we = seq_finish && (seq_op == OP_PROG) && !seq_fault;
  assign arr_wd = arr_q | {padm, pdat} | (ROW_BITS'(1) << HALF_BITS);

  fuse_array #(.ROWS(ROWS), .WIDTH(ROW_BITS)) u_arr (
    .clk(clk), .rd_idx(seq_row), .rd_q(arr_q),
    .we(arr_we), .wr_idx(seq_row), .wr_d(arr_wd)
  );

  // configuration registers and soft protect
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q  <= '0;
      pdat    <= '0;
      padm    <= '0;
      soft_wp <= 1'b1;
    end else begin
      if (bus_wr && win_prot && (off == 8'h00)) soft_wp <= bus_wdata[3];
      if (cfg_wr) begin
        if (off == OFF_ADDR) addr_q <= bus_wdata;
        if (off[7:4] == GRP_PDAT) pdat[off[3:2]] <= bus_wdata;
        if (off[7:4] == GRP_PADM) padm[off[3:2]] <= bus_wdata;
      end
    end
  end

  // results captured at completion
  always_ff @(posedge clk) begin
    if (rst) begin
      rdat    <= '0;
      radm    <= '0;
      rd_stat <= '0;
      pg_stat <= '0;
    end else if (seq_finish) begin
      if (seq_op == OP_READ) begin
        rd_stat <= {31'd0, seq_fault};
        rdat    <= seq_fault ? '0 : arr_q[HALF_BITS-1:0];
        radm    <= seq_fault ? '0 : arr_q[ROW_BITS-1:HALF_BITS];
      end
      if (seq_op == OP_PROG) pg_stat <= {31'd0, seq_fault};
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (win_prot) begin
        bus_rdata <= (off == 8'h00) ? {1'b0, ext_wp, 26'd0, soft_wp, 3'd0} : '0;
      end else begin
        unique case (off[7:4])
          4'h0: begin
            case (off)
              OFF_GSTAT: bus_rdata <= {31'd0, !seq_busy};
              OFF_RSTAT: bus_rdata <= rd_stat;
              OFF_PSTAT: bus_rdata <= pg_stat;
              default:   bus_rdata <= '0;
            endcase
          end
          4'h1: begin
            case (off)
              OFF_ADDR: bus_rdata <= addr_q;
              OFF_CTRL: bus_rdata <= {15'd0, seq_done, 8'd0, seq_cmd, 4'd0};
              default:  bus_rdata <= '0;
            endcase
          end
          GRP_RDAT: bus_rdata <= rdat[off[3:2]];
          GRP_RADM: bus_rdata <= radm[off[3:2]];
          GRP_PDAT: bus_rdata <= pdat[off[3:2]];
          GRP_PADM: bus_rdata <= padm[off[3:2]];
          default:  bus_rdata <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/fuse_cmd_engine_chk.sv
module fuse_cmd_engine_chk #(
  parameter int unsigned PROG_LAT = 32
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic start_fire,
  input logic arr_we,
  input logic ext_wp,
  input logic soft_wp
);
  localparam int unsigned CW = $clog2(PROG_LAT + 2) + 1;
  logic [CW-1:0] busy_run;
  logic          blocked_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_run  <= '0;
      blocked_q <= 1'b0;
    end else begin
      busy_run <= busy ? busy_run + 1'b1 : '0;
      if (start_fire) blocked_q <= ext_wp || soft_wp;
    end
  end

  AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    start_fire |=> busy) else $error("start did not raise busy"); // R3
  AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (rst)
    busy_run <= CW'(PROG_LAT)) else $error("busy too long"); // R3
  AST_DONE_NOT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done) else $error("done while busy"); // R4
  AST_DONE_WITH_READY: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done) else $error("done missing at completion"); // R4
  AST_WRITE_AT_END: assert property (@(posedge clk) disable iff (rst)
    arr_we |=> (done && !busy)) else $error("array write not at completion"); // R5
  AST_PROTECT_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> !blocked_q) else $error("protected program wrote array"); // R7
endmodule

bind fuse_cmd_engine fuse_cmd_engine_chk #(.PROG_LAT(PROG_LAT)) u_chk (
  .clk(clk), .rst(rst), .busy(seq_busy), .done(seq_done),
  .start_fire(start_fire), .arr_we(arr_we), .ext_wp(ext_wp), .soft_wp(soft_wp)
);

// File: tb/fuse_cmd_engine_bench.sv
module fuse_cmd_engine_bench;
  localparam int ROWS = 16;
  localparam int RLAT = 8;
  localparam int PLAT = 32;
  localparam logic [12:0] PROT = 13'h1000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        ext_wp = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] model [ROWS][8];

  always #4 clk = ~clk;

  fuse_cmd_engine #(.ROWS(ROWS), .READ_LAT(RLAT), .PROG_LAT(PLAT)) u_fuse_cmd_engine (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .ext_wp(ext_wp)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_wr = 1'b0;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // start a command and count the polled samples showing ready low
  task automatic run_cmd(input logic [3:0] code, output int lows);
    lows = 0;
    @(negedge clk);
    bus_addr = 13'h014; bus_wdata = {24'd0, code, 4'h1}; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 13'h000; bus_rd = 1'b1;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (bus_rdata[0]) break;
      lows++;
    end
    bus_rd = 1'b0;
  endtask

  function automatic logic [31:0] pat(input int r, input int w, input int s);
    return (32'h01010101 * (r + 1)) ^ (32'h00100000 << w) ^ (32'h0F0F0000 * s);
  endfunction

  task automatic load_prog(input int r, input int s);
    wr(13'h010, 32'(r * 16));
    for (int w = 0; w < 4; w++) wr(13'(13'h040 + 4 * w), pat(r, w, s));
    for (int w = 0; w < 4; w++) wr(13'(13'h050 + 4 * w), pat(r, w + 4, s));
  endtask

  task automatic check_row(input int r, input string req);
    logic [31:0] d;
    int lows;
    wr(13'h010, 32'(r * 16));
    run_cmd(4'hF, lows);
    check(lows == RLAT, "R3 read latency", 32'(lows), 32'(RLAT));
    rd(13'h004, d);
    check(d == 0, req, d, 0);
    for (int w = 0; w < 4; w++) begin
      rd(13'(13'h020 + 4 * w), d);
      check(d == model[r][w], {req, " R6 data"}, d, model[r][w]);
      rd(13'(13'h030 + 4 * w), d);
      check(d == model[r][w+4], {req, " R6 admin"}, d, model[r][w+4]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
    $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int lows;
    for (int r = 0; r < ROWS; r++)
      for (int w = 0; w < 8; w++) model[r][w] = '0;

    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(13'h000, d); check(d == 32'h1, "R1 ready", d, 32'h1);
    rd(13'h014, d); check(d == 32'h0, "R1 control", d, 32'h0);
    rd(13'h004, d); check(d == 32'h0, "R1 read status", d, 0);
    rd(13'h008, d); check(d == 32'h0, "R1 prog status", d, 0);
    rd(PROT, d); check(d == 32'h8, "R1 soft protect", d, 32'h8);

    // R2 blank rows
    for (int r = 0; r < ROWS; r++) check_row(r, "R2 blank");

    // R4/R10 control after a read
    rd(13'h014, d); check(d == 32'h000100F0, "R4 R10 control", d, 32'h000100F0);

    // R7 soft protect set by default
    load_prog(2, 0);
    run_cmd(4'hA, lows);
    check(lows == PLAT, "R3 prog latency", 32'(lows), 32'(PLAT));
    rd(13'h008, d); check(d == 32'h1, "R7 soft blocked", d, 1);
    check_row(2, "R7 unchanged");

    // clear soft protect, program every row
    wr(PROT, 32'h0);
    rd(PROT, d); check(d == 32'h0, "R7 soft cleared", d, 0);
    for (int r = 0; r < ROWS; r++) begin
      load_prog(r, 0);
      run_cmd(4'hA, lows);
      check(lows == PLAT, "R3 prog latency", 32'(lows), 32'(PLAT));
      rd(13'h008, d); check(d == 32'h0, "R7 allowed", d, 0);
      for (int w = 0; w < 4; w++) model[r][w] = pat(r, w, 0);
      for (int w = 0; w < 4; w++) model[r][w+4] = pat(r, w + 4, 0);
      model[r][4] |= 32'h1;
    end
    for (int r = 0; r < ROWS; r++) check_row(r, "R5 programmed");

    // R5 second program ORs into row 3
    load_prog(3, 1);
    run_cmd(4'hA, lows);
    for (int w = 0; w < 4; w++) model[3][w] |= pat(3, w, 1);
    for (int w = 0; w < 4; w++) model[3][w+4] |= pat(3, w + 4, 1);
    check_row(3, "R5 or-merge");

    // R7 external pin blocks
    ext_wp = 1'b1;
    rd(PROT, d); check(d == 32'h40000000, "R7 pin visible", d, 32'h40000000);
    load_prog(5, 1);
    run_cmd(4'hA, lows);
    rd(13'h008, d); check(d == 32'h1, "R7 pin blocked", d, 1);
    ext_wp = 1'b0;
    check_row(5, "R7 unchanged pin");

    // R8 misaligned and out-of-range
    for (int k = 1; k < 16; k++) begin
      wr(13'h010, 32'(7 * 16 + k));
      run_cmd(4'hF, lows);
      rd(13'h004, d); check(d == 32'h1, "R8 misaligned read status", d, 1);
      rd(13'h020, d); check(d == 32'h0, "R8 misaligned data", d, 0);
      rd(13'h030, d); check(d == 32'h0, "R8 misaligned admin", d, 0);
      run_cmd(4'hA, lows);
      rd(13'h008, d); check(d == 32'h1, "R8 misaligned prog status", d, 1);
    end
    check_row(7, "R8 row intact");
    wr(13'h010, 32'(ROWS * 16));
    run_cmd(4'hF, lows);
    rd(13'h004, d); check(d == 32'h1, "R8 range read status", d, 1);
    run_cmd(4'hA, lows);
    rd(13'h008, d); check(d == 32'h1, "R8 range prog status", d, 1);

    // R9 / R3 writes while busy
    load_prog(9, 1);
    wr(13'h010, 32'(4 * 16));
    @(negedge clk);
    bus_addr = 13'h014; bus_wdata = 32'h000000F1; bus_wr = 1'b1;
    @(negedge clk);
    bus_wdata = 32'h000000A1;
    @(negedge clk);
    bus_addr = 13'h010; bus_wdata = 32'h00000020;
    @(negedge clk);
    bus_addr = 13'h040; bus_wdata = 32'hFFFFFFFF;
    @(negedge clk);
    bus_wr = 1'b0;
    repeat (RLAT + 4) @(negedge clk);
    rd(13'h014, d); check(d == 32'h000100F0, "R3 R10 busy start ignored", d, 32'h000100F0);
    rd(13'h010, d); check(d == 32'h40, "R9 address kept", d, 32'h40);
    rd(13'h040, d); check(d == pat(9, 0, 1), "R9 payload kept", d, pat(9, 0, 1));
    rd(13'h020, d); check(d == model[4][0], "R6 read of row 4", d, model[4][0]);
    check_row(4, "R3 no program");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule